// File: doc/BRIEF.md
# Status Register Condition Code Unit

This unit holds a processor's 16-bit status word and keeps its condition-code, carry and overflow fields up to date as the ALU produces results. On a condition-code update strobe it writes a two-bit code derived from one of three patterns. The arithmetic pattern classifies a one- to four-word operand by sign and zero. The byte pattern classifies an ASCII character as digit, letter or other. The compare pattern orders two two-word operands, signed or unsigned. Carry and overflow events write their own bits. An overflow event with user traps enabled also raises a one-cycle request toward the interrupt register.

In the stored code, "greater" is the all-zeros value. A bitwise AND with an instruction mask would therefore never match it. The unit remaps the stored code into a one-hot three-bit flag. A conditional-branch or move-while test is then a single AND with the instruction's flag mask, and it passes when any bit survives. A whole-word load port lets the surrounding control set the mode and enable bits.

Top module: `ccode_status_unit`

## Requirements
- R1: After a cycle with rst_n low, status_word is 0x0000 and ovf_req is 0.
- R2: With status_load high, status_word takes status_din at the next edge, and every field update in that cycle is discarded. ovf_req is then 0.
- R3: The condition code sits in status_word[9:8] with 00 = greater, 01 = less, 10 = equal. With cc_update high and cc_pattern = 1 (arithmetic), the operand is the low arith_size+1 16-bit words of opnd_a. Its most significant word is word arith_size. The code is equal if every word of the operand is zero, less if cmp_signed is 1 and bit 15 of the most significant word is 1, and greater otherwise.
- R4: With cc_pattern = 2 (byte), opnd_a[7:0] in 0x30..0x39 gives greater, 0x41..0x5A or 0x61..0x7A gives equal, and any other value gives less.
- R5: With cc_pattern = 3 (compare), operand 1 is opnd_a[31:0] and operand 2 is opnd_b[31:0], each with its upper word in bits 31:16. If the upper words are equal, the lower words are compared unsigned. Otherwise the upper words are compared with bit 15 inverted when cmp_signed is 1, or plainly when it is 0. A lower operand 1 gives less, a higher one gives greater, and equal gives equal.
- R6: A condition-code update changes only bits 9:8. With cc_pattern = 0 the code is left unchanged.
- R7: With carry_we high, status_word[10] takes carry_in at the next edge.
- R8: With ovf_we high, status_word[11] takes ovf_in at the next edge. ovf_req is 1 in the following cycle exactly when ovf_in is 1 and the trap-enable bit status_word[13] was 1 before the edge.
- R9: test_pass is the OR of flag_mask ANDed with the one-hot flag of the stored code, where bit 0 = less, bit 1 = equal and bit 2 = greater. A mask with bits 1 and 2 both set passes for both letters and digits.
- R10: A stored code of 11 yields an all-zero flag, so test_pass is 0 for every mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status_load | input | 1 | Load the whole status word |
| status_din | input | 16 | Word to load |
| cc_update | input | 1 | Condition-code update strobe |
| cc_pattern | input | 2 | 0 none, 1 arithmetic, 2 byte, 3 compare |
| arith_size | input | 2 | Arithmetic operand size minus one, in words |
| cmp_signed | input | 1 | Signed interpretation for arithmetic and compare |
| opnd_a | input | 64 | Operand words (arithmetic, byte, compare operand 1) |
| opnd_b | input | 32 | Compare operand 2 |
| carry_we | input | 1 | Carry update strobe |
| carry_in | input | 1 | New carry value |
| ovf_we | input | 1 | Overflow update strobe |
| ovf_in | input | 1 | Overflow event |
| flag_mask | input | 3 | Instruction flag mask (bit0 less, bit1 equal, bit2 greater) |
| status_word | output | 16 | Stored status word |
| test_pass | output | 1 | Flag mask test result |
| ovf_req | output | 1 | Integer-overflow request pulse |

## Verification
The checker watches several properties on every cycle. An update never stores the invalid code. Fields outside the strobed ones hold. A load wins over field updates. A carry write lands in its bit. An overflow request appears only with the trap and overflow bits set, and it always follows a trapped overflow event. A stored invalid code never passes a test. The bench alone shows that the right code is chosen, because that takes the classification boundaries, the operand-size selection, and the signed and unsigned ordering across the sign-flip cases. Each of these is compared against bench models over random and directed operands.

// File: rtl/ccu_pkg.sv
// Shared encodings for the status condition-code unit.
// Assumes bit 15 of the status word is its most significant (mode) bit.
package ccu_pkg;
    typedef enum logic [1:0] {
        PAT_NONE  = 2'd0,
        PAT_ARITH = 2'd1,
        PAT_BYTE  = 2'd2,
        PAT_CMP   = 2'd3
    } ccu_pat_e;

    localparam logic [1:0] CC_GT  = 2'b00;
    localparam logic [1:0] CC_LT  = 2'b01;
    localparam logic [1:0] CC_EQ  = 2'b10;
    localparam logic [1:0] CC_BAD = 2'b11;

    localparam int SW_TRAP  = 13;
    localparam int SW_OVF   = 11;
    localparam int SW_CARRY = 10;
    localparam int SW_CC_LO = 8;
endpackage

// File: rtl/ccu_cc_select.sv
// Computes the candidate two-bit condition code for the selected pattern.
// Purely combinational; assumes WORD_W >= 8 and opnd_b holds two words.
module ccu_cc_select
    import ccu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NWORDS = 4,
    localparam int SZ_W  = $clog2(NWORDS)
) (
    input  logic [1:0]               pattern,
    input  logic [SZ_W-1:0]          size,
    input  logic                     is_signed,
    input  logic [NWORDS*WORD_W-1:0] opa,
    input  logic [2*WORD_W-1:0]      opb,
    output logic [1:0]               cc_out
);
    logic [NWORDS-1:0] word_nz;
    logic [1:0] cc_arith, cc_byte, cc_cmp;

    // Per-word nonzero detect for the arithmetic pattern
    for (genvar w = 0; w < NWORDS; w++) begin : g_nz
        assign word_nz[w] = |opa[w*WORD_W +: WORD_W];
    end

    // Arithmetic pattern: zero over the selected words, sign from the top word
    always_comb begin
        logic any_nz;
        logic sgn;
        any_nz = 1'b0;
        for (int i = 0; i < NWORDS; i++) begin
            if (i <= int'(size)) any_nz = any_nz | word_nz[i];
        end
        sgn = opa[(int'(size) + 1) * WORD_W - 1] & is_signed;
        if (!any_nz)  cc_arith = CC_EQ;
        else if (sgn) cc_arith = CC_LT;
        else          cc_arith = CC_GT;
    end

    // Byte pattern: ASCII digit, letter or other
    always_comb begin
        logic [7:0] ch;
        ch = opa[7:0];
        if (ch >= 8'h30 && ch <= 8'h39)
            cc_byte = CC_GT;
        else if ((ch >= 8'h41 && ch <= 8'h5A) || (ch >= 8'h61 && ch <= 8'h7A))
            cc_byte = CC_EQ;
        else
            cc_byte = CC_LT;
    end

    // Compare pattern: upper words with optional sign flip, then lower words
    always_comb begin
        logic [WORD_W-1:0] ahi, bhi, alo, blo, flip;
        flip = {is_signed, {(WORD_W-1){1'b0}}};
        ahi  = opa[2*WORD_W-1:WORD_W];
        alo  = opa[WORD_W-1:0];
        bhi  = opb[2*WORD_W-1:WORD_W];
        blo  = opb[WORD_W-1:0];
        if (ahi == bhi) begin
            if (alo == blo)     cc_cmp = CC_EQ;
            else if (alo < blo) cc_cmp = CC_LT;
            else                cc_cmp = CC_GT;
        end else if ((ahi ^ flip) < (bhi ^ flip)) begin
            cc_cmp = CC_LT;
        end else begin
            cc_cmp = CC_GT;
        end
    end

    // Pattern mux
    always_comb begin
        unique case (ccu_pat_e'(pattern))
            PAT_ARITH: cc_out = cc_arith;
            PAT_BYTE:  cc_out = cc_byte;
            PAT_CMP:   cc_out = cc_cmp;
            default:   cc_out = CC_BAD;
        endcase
    end
endmodule

// File: rtl/ccu_flag_test.sv
// Remaps the stored code to a one-hot flag and tests it against a mask.
// Assumes flag order bit0 less, bit1 equal, bit2 greater; code 11 maps to 000.
module ccu_flag_test
    import ccu_pkg::*;
(
    input  logic [1:0] cc,
    input  logic [2:0] mask,
    output logic       pass
);
    logic [2:0] hot;

    // One-hot remap with greater moved to its own bit
    always_comb begin
        hot[0] = (cc == CC_LT);
        hot[1] = (cc == CC_EQ);
        hot[2] = (cc == CC_GT);
        pass   = |(hot & mask);
    end
endmodule

// File: rtl/ccode_status_unit.sv
// Status word register with condition-code, carry and overflow update paths.
// Assumes a whole-word load overrides every field update in the same cycle;
// the overflow request uses the trap-enable bit stored before the edge.
module ccode_status_unit
    import ccu_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NWORDS = 4,
    localparam int SZ_W  = $clog2(NWORDS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     status_load,
    input  logic [WORD_W-1:0]        status_din,
    input  logic                     cc_update,
    input  logic [1:0]               cc_pattern,
    input  logic [SZ_W-1:0]          arith_size,
    input  logic                     cmp_signed,
    input  logic [NWORDS*WORD_W-1:0] opnd_a,
    input  logic [2*WORD_W-1:0]      opnd_b,
    input  logic                     carry_we,
    input  logic                     carry_in,
    input  logic                     ovf_we,
    input  logic                     ovf_in,
    input  logic [2:0]               flag_mask,
    output logic [WORD_W-1:0]        status_word,
    output logic                     test_pass,
    output logic                     ovf_req
);
    logic [1:0] cc_next;
    logic       cc_write;

    ccu_cc_select #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_sel (
        .pattern   (cc_pattern),
        .size      (arith_size),
        .is_signed (cmp_signed),
        .opa       (opnd_a),
        .opb       (opnd_b),
        .cc_out    (cc_next)
    );

    ccu_flag_test u_test (
        .cc   (status_word[SW_CC_LO +: 2]),
        .mask (flag_mask),
        .pass (test_pass)
    );

    // A code write needs a real pattern
    assign cc_write = cc_update && (cc_pattern != PAT_NONE);

    // Status word and overflow request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_word <= '0;
            ovf_req     <= 1'b0;
        end else if (status_load) begin
            status_word <= status_din;
            ovf_req     <= 1'b0;
        end else begin
            if (cc_write) status_word[SW_CC_LO +: 2] <= cc_next;
            if (carry_we) status_word[SW_CARRY]      <= carry_in;
            if (ovf_we)   status_word[SW_OVF]        <= ovf_in;
            ovf_req <= ovf_we && ovf_in && status_word[SW_TRAP];
        end
    end
endmodule

// File: rtl/ccode_status_unit_chk.sv
// Cycle-level properties of the status condition-code unit, bound to its top.
module ccode_status_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        status_load,
    input logic [15:0] status_din,
    input logic        cc_update,
    input logic [1:0]  cc_pattern,
    input logic        carry_we,
    input logic        carry_in,
    input logic        ovf_we,
    input logic        ovf_in,
    input logic [2:0]  flag_mask,
    input logic [15:0] status_word,
    input logic        test_pass,
    input logic        ovf_req
);
    a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        status_load |=> (status_word == $past(status_din)) && !ovf_req);

    a_r6_cc_never_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_update && cc_pattern != 2'd0 && !status_load) |=> status_word[9:8] != 2'b11);

    a_r6_fields_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_load && !carry_we && !ovf_we) |=>
        (status_word[15:10] == $past(status_word[15:10])) &&
        (status_word[7:0] == $past(status_word[7:0])));

    a_r7_carry_written: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_we && !status_load) |=> status_word[10] == $past(carry_in));

    a_r8_req_needs_trap: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_req |-> status_word[13] && status_word[11]);

    a_r8_req_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_we && ovf_in && status_word[13] && !status_load) |=> ovf_req);

    a_r10_invalid_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[9:8] == 2'b11) |-> !test_pass);
endmodule

bind ccode_status_unit ccode_status_unit_chk u_chk (.*);

// File: tb/ccode_status_unit_bench.sv
module ccode_status_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        status_load;
    logic [15:0] status_din;
    logic        cc_update;
    logic [1:0]  cc_pattern;
    logic [1:0]  arith_size;
    logic        cmp_signed;
    logic [63:0] opnd_a;
    logic [31:0] opnd_b;
    logic        carry_we, carry_in, ovf_we, ovf_in;
    logic [2:0]  flag_mask;
    logic [15:0] status_word;
    logic        test_pass, ovf_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] exp_sw;
    logic        exp_req;

    always #10 clk = ~clk;

    ccode_status_unit u_ccode_status_unit (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [1:0] m_arith(input logic [63:0] a, input logic [1:0] sz, input logic sg);
        logic nz = 1'b0;
        for (int i = 0; i < 4; i++) if (i <= int'(sz)) nz |= (a[i*16 +: 16] != 16'h0);
        if (!nz) return 2'b10;
        if (sg && a[int'(sz)*16 + 15]) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [1:0] m_byte(input logic [7:0] c);
        if (c >= "0" && c <= "9") return 2'b00;
        if ((c >= "A" && c <= "Z") || (c >= "a" && c <= "z")) return 2'b10;
        return 2'b01;
    endfunction

    function automatic logic [1:0] m_cmp(input logic [31:0] a, input logic [31:0] b, input logic sg);
        longint va, vb;
        if (sg) begin
            va = longint'($signed(a[31:16])) * 65536 + longint'(a[15:0]);
            vb = longint'($signed(b[31:16])) * 65536 + longint'(b[15:0]);
        end else begin
            va = longint'(a); vb = longint'(b);
        end
        if (va == vb) return 2'b10;
        return (va < vb) ? 2'b01 : 2'b00;
    endfunction

    function automatic logic m_pass(input logic [1:0] cc, input logic [2:0] m);
        logic [2:0] h;
        h = {cc == 2'b00, cc == 2'b10, cc == 2'b01};
        return |(h & m);
    endfunction

    task automatic idle();
        status_load = 0; status_din = '0; cc_update = 0; cc_pattern = 0;
        arith_size = 0; cmp_signed = 0; opnd_a = '0; opnd_b = '0;
        carry_we = 0; carry_in = 0; ovf_we = 0; ovf_in = 0;
    endtask

    // Apply the inputs set at this negedge, update the model, check at the next negedge
    task automatic cycle(input string req);
        logic [1:0] cc;
        logic       trap_before;
        trap_before = exp_sw[13];
        if (status_load) begin
            exp_sw = status_din; exp_req = 0;
        end else begin
            unique case (cc_pattern)
                2'd1: cc = m_arith(opnd_a, arith_size, cmp_signed);
                2'd2: cc = m_byte(opnd_a[7:0]);
                2'd3: cc = m_cmp(opnd_a[31:0], opnd_b, cmp_signed);
                default: cc = exp_sw[9:8];
            endcase
            if (cc_update) exp_sw[9:8] = cc;
            if (carry_we) exp_sw[10] = carry_in;
            if (ovf_we) exp_sw[11] = ovf_in;
            exp_req = ovf_we && ovf_in && trap_before;
        end
        @(negedge clk);
        chk(status_word == exp_sw, req, 32'(status_word), 32'(exp_sw));
        chk(ovf_req == exp_req, "R8 ovf_req", 32'(ovf_req), 32'(exp_req));
        chk(test_pass == m_pass(exp_sw[9:8], flag_mask), "R9 test_pass",
            32'(test_pass), 32'(m_pass(exp_sw[9:8], flag_mask)));
    endtask

    task automatic byte_case(input logic [7:0] c);
        idle(); cc_update = 1; cc_pattern = 2; opnd_a = {56'h0, c}; flag_mask = 3'b110;
        cycle("R4 byte class");
    endtask

    task automatic cmp_case(input logic [31:0] a, input logic [31:0] b, input logic sg);
        idle(); cc_update = 1; cc_pattern = 3; opnd_a = {32'h0, a}; opnd_b = b; cmp_signed = sg;
        cycle("R5 compare");
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle(); flag_mask = 3'b000; rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk(status_word == 16'h0, "R1 reset word", 32'(status_word), 0);
        chk(ovf_req == 1'b0, "R1 reset req", 32'(ovf_req), 0);
        exp_sw = '0; exp_req = 0;
        rst_n = 1;

        // R9: reset code is greater; mask greater-only passes
        idle(); flag_mask = 3'b100; cycle("R9 greater after reset");

        // R3: arithmetic sizes with sign in the top word only
        idle(); cc_update = 1; cc_pattern = 1; cmp_signed = 1; arith_size = 1;
        opnd_a = 64'h0000_0000_8000_0000; cycle("R3 32-bit negative");
        idle(); cc_update = 1; cc_pattern = 1; cmp_signed = 1; arith_size = 0;
        opnd_a = 64'h0000_0000_8000_0000; cycle("R3 16-bit zero, upper ignored");
        idle(); cc_update = 1; cc_pattern = 1; cmp_signed = 0; arith_size = 3;
        opnd_a = 64'h8000_0000_0000_0000; cycle("R3 64-bit unsigned greater");
        idle(); cc_update = 1; cc_pattern = 1; cmp_signed = 1; arith_size = 2;
        opnd_a = 64'h0000_FFFF_0000_0001; cycle("R3 48-bit signed less");

        // R4: byte class boundaries; R9 mask with both letter and digit bits
        byte_case(8'h2F); byte_case(8'h30); byte_case(8'h39); byte_case(8'h3A);
        byte_case(8'h40); byte_case(8'h41); byte_case(8'h5A); byte_case(8'h5B);
        byte_case(8'h60); byte_case(8'h61); byte_case(8'h7A); byte_case(8'h7B);

        // R5: sign-flip compare cases
        cmp_case(32'hFFFF_0000, 32'h0001_0000, 1'b1);
        cmp_case(32'hFFFF_0000, 32'h0001_0000, 1'b0);
        cmp_case(32'h0005_FFFF, 32'h0005_0001, 1'b1);
        cmp_case(32'h1234_5678, 32'h1234_5678, 1'b1);

        // R6: pattern none leaves code; R10: invalid code fails every mask
        idle(); status_load = 1; status_din = 16'h2300; flag_mask = 3'b111; cycle("R2 load");
        idle(); cc_update = 1; cc_pattern = 0; opnd_a = 64'h1; cycle("R6 pattern none");
        chk(test_pass == 1'b0, "R10 invalid code", 32'(test_pass), 0);

        // R2: load beats field updates in the same cycle
        idle(); status_load = 1; status_din = 16'h0000; carry_we = 1; carry_in = 1;
        ovf_we = 1; ovf_in = 1; cc_update = 1; cc_pattern = 2; opnd_a = 64'h41;
        cycle("R2 load priority");

        // R8: trap enabled and disabled overflow events, then clear
        idle(); status_load = 1; status_din = 16'h2000; cycle("R2 trap on");
        idle(); ovf_we = 1; ovf_in = 1; cycle("R8 overflow trapped");
        idle(); ovf_we = 1; ovf_in = 0; cycle("R8 overflow cleared");
        idle(); status_load = 1; status_din = 16'h0000; cycle("R2 trap off");
        idle(); ovf_we = 1; ovf_in = 1; cycle("R8 overflow untrapped");
        idle(); carry_we = 1; carry_in = 1; cycle("R7 carry set");

        // Random mix across all paths
        for (int n = 0; n < 1500; n++) begin
            idle();
            status_load = ($urandom_range(0, 15) == 0);
            status_din  = 16'($urandom());
            cc_update   = $urandom_range(0, 1);
            cc_pattern  = 2'($urandom());
            arith_size  = 2'($urandom());
            cmp_signed  = $urandom_range(0, 1);
            opnd_a      = {32'($urandom()), 32'($urandom())};
            if ($urandom_range(0, 3) == 0) opnd_a[31:0] = 32'h0;
            if ($urandom_range(0, 3) == 0) opnd_a[7:0] = 8'($urandom_range(32'h2C, 32'h7D));
            opnd_b      = 32'($urandom());
            if ($urandom_range(0, 2) == 0) opnd_b[31:16] = opnd_a[31:16];
            carry_we    = $urandom_range(0, 1);
            carry_in    = $urandom_range(0, 1);
            ovf_we      = $urandom_range(0, 1);
            ovf_in      = $urandom_range(0, 1);
            flag_mask   = 3'($urandom());
            cycle("R3 R4 R5 R6 R7 random status");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule